// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps the bookkeeping for packets sitting in a receive FIFO, without holding the packet bytes themselves. The MAC side reports three kinds of event: a packet begins, a byte was stored, and a packet ends. The end event carries an error code. For each packet the queue keeps a descriptor with a byte count, an error field and a completion mark. The oldest descriptor is shown to the host as one 16-bit status word.

The host reads the payload one byte at a time, and the block counts how far it has read into the oldest packet. It can drop the oldest packet with a discard strobe. It can clear the whole queue with a receive-reset strobe. Two things are visible as flags: a full queue, which refuses new packets, and a read past the received bytes, which is a sticky failure.

Top module: `rx_pkt_status_queue`

## Requirements
- R1: After reset the status word is 0x8000, the consumed count is 0, and receiving, stat_overrun, rx_underrun, adapter_fail, rx_complete and refused_cnt are all 0.
- R2: While a packet is being written, receiving is 1. If that packet is the oldest, status bit 15 is 1 and bits 10..0 show the bytes received so far.
- R3: A completed oldest packet shows bit 15 = 0 and its byte count in bits 10..0. Bits 14..11 carry the error field for the MAC code on mac_err: 0 none → 0000, 1 overrun → 1000, 2 runt → 1011, 3 alignment → 1100, 4 CRC → 1101, 5 dribble → 0010.
- R4: The byte count saturates at MAX_LEN (1514 by default). A packet with more bytes gets the oversize field 1001, unless the MAC reported a nonzero code, in which case that code is used. A packet of exactly MAX_LEN bytes is not oversize.
- R5: The queue holds at most DEPTH descriptors, counting the one being written. When DEPTH are held, stat_overrun is 1 and a new packet start is refused. refused_cnt rises by one, no descriptor is created, and the bytes and end of that packet are ignored, with no rx_complete.
- R6: stat_overrun drops with no host action as soon as one descriptor has been removed.
- R7: Each host_rd pulse raises rd_count by one while rd_count is below the byte count of the oldest packet, even if that packet is still arriving.
- R8: A host_rd with the queue empty, or with rd_count equal to the oldest packet's count, sets rx_underrun and adapter_fail. Both stay set until rx_reset or rst_n.
- R9: host_discard removes a completed oldest packet whether or not it was read, and returns rd_count to 0.
- R10: host_discard has no effect when the queue is empty or when the oldest packet is still arriving.
- R11: rx_complete is a one-cycle pulse in the first cycle in which the ended packet's descriptor is marked complete.
- R12: rx_reset empties the queue, aborts a packet in progress, and clears rx_underrun, adapter_fail and refused_cnt.
- R13: Packets are presented and removed strictly oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mac_start | input | 1 | A new packet begins |
| mac_byte | input | 1 | One byte of the current packet was stored |
| mac_end | input | 1 | The current packet ends |
| mac_err | input | 3 | MAC error code, taken with mac_end |
| host_rd | input | 1 | Host consumes one byte of the oldest packet |
| host_discard | input | 1 | Drop the oldest packet |
| rx_reset | input | 1 | Clear the receive queue and its flags |
| status_word | output | 16 | Status of the oldest packet |
| rd_count | output | 11 | Bytes consumed from the oldest packet |
| receiving | output | 1 | A packet is being written into the queue |
| stat_overrun | output | 1 | Queue full, new packets refused |
| rx_underrun | output | 1 | Sticky: a read went past the received bytes |
| adapter_fail | output | 1 | Failure indication raised by rx_underrun |
| rx_complete | output | 1 | Pulse when a packet is complete |
| refused_cnt | output | REF_W | Saturating count of refused packets |

## Verification
The bench builds the queue with DEPTH = 4 and MAX_LEN = 20. With the small depth, the full condition, the refusal of a fifth packet and the self-clearing after one discard each take only a few short packets. With the small length limit, the saturation boundary can be tested at exactly the limit, one step past it, and past it with a MAC error code competing with the oversize mark.

// File: rtl/rxq_pkg.sv
// Package: shared encodings for the receive status queue.
// Assumes the host-visible status layout: bit 15 busy/empty, bits 14..11
// error field, bits 10..0 byte count.
package rxq_pkg;
    localparam int STAT_W = 16;
    localparam int LEN_W  = 11;

    // Error codes presented by the MAC with its end-of-packet event.
    localparam logic [2:0] MERR_NONE    = 3'd0;
    localparam logic [2:0] MERR_OVERRUN = 3'd1;
    localparam logic [2:0] MERR_RUNT    = 3'd2;
    localparam logic [2:0] MERR_ALIGN   = 3'd3;
    localparam logic [2:0] MERR_CRC     = 3'd4;
    localparam logic [2:0] MERR_DRIBBLE = 3'd5;

    // Error field values as the host decodes them (bits 14..11).
    localparam logic [3:0] FLD_NONE     = 4'b0000;
    localparam logic [3:0] FLD_OVERRUN  = 4'b1000;
    localparam logic [3:0] FLD_RUNT     = 4'b1011;
    localparam logic [3:0] FLD_ALIGN    = 4'b1100;
    localparam logic [3:0] FLD_CRC      = 4'b1101;
    localparam logic [3:0] FLD_OVERSIZE = 4'b1001;
    localparam logic [3:0] FLD_DRIBBLE  = 4'b0010;

    // Map a MAC code plus the oversize mark to the host error field.
    // A reported MAC error wins over the length-derived oversize mark.
    function automatic logic [3:0] err_field(input logic [2:0] code, input logic oversize);
        logic [3:0] f;
        case (code)
            MERR_OVERRUN: f = FLD_OVERRUN;
            MERR_RUNT:    f = FLD_RUNT;
            MERR_ALIGN:   f = FLD_ALIGN;
            MERR_CRC:     f = FLD_CRC;
            MERR_DRIBBLE: f = FLD_DRIBBLE;
            default:      f = oversize ? FLD_OVERSIZE : FLD_NONE;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/rxq_desc_store.sv
// Descriptor ring: one entry per packet held in the receive FIFO.
// Assumes a well-formed MAC event stream: start, bytes, end; a start while a
// packet is open is ignored. Entries are allocated at the tail, popped at the
// head only when complete. A start while full is refused and its bytes and
// end are swallowed.
module rxq_desc_store
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int MAX_LEN = 1514,
    parameter int REF_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             mac_start,
    input  logic             mac_byte,
    input  logic             mac_end,
    input  logic [2:0]       mac_err,
    input  logic             pop_req,
    output logic [LEN_W-1:0] head_cnt,
    output logic [3:0]       head_fld,
    output logic             head_done,
    output logic             empty,
    output logic             full,
    output logic             receiving,
    output logic             rx_complete,
    output logic             pop,
    output logic [REF_W-1:0] refused_cnt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] cnt_q  [DEPTH];
    logic [3:0]       fld_q  [DEPTH];
    logic             done_q [DEPTH];

    logic [PTR_W-1:0] head_q, tail_q, cur_q;
    logic [OCC_W-1:0] occ_q;
    logic             recv_q, drop_q, ovsz_q, cmpl_q;
    logic [REF_W-1:0] ref_q;

    logic idle_mac, accept, refuse, byte_ok, ovsz_hit, end_ok;

    // Next pointer position with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Event qualification against the current ring state.
    always_comb begin
        empty    = (occ_q == '0);
        full     = (occ_q == OCC_W'(DEPTH));
        idle_mac = !recv_q && !drop_q;
        accept   = mac_start && idle_mac && !full;
        refuse   = mac_start && idle_mac && full;
        byte_ok  = recv_q && mac_byte && (cnt_q[cur_q] != LEN_CAP);
        ovsz_hit = recv_q && mac_byte && (cnt_q[cur_q] == LEN_CAP);
        end_ok   = recv_q && mac_end;
        pop      = pop_req && !empty && done_q[head_q];
    end

    // Per-entry storage: allocate, count bytes, close, release on pop.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic sel_new, sel_cur, sel_pop;
        assign sel_new = accept && (tail_q == PTR_W'(g));
        assign sel_cur = recv_q && (cur_q == PTR_W'(g));
        assign sel_pop = pop && (head_q == PTR_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g]  <= '0;
                fld_q[g]  <= '0;
                done_q[g] <= 1'b0;
            end else if (clr) begin
                done_q[g] <= 1'b0;
            end else if (sel_new) begin
                cnt_q[g]  <= '0;
                fld_q[g]  <= '0;
                done_q[g] <= 1'b0;
            end else if (sel_cur) begin
                if (byte_ok) cnt_q[g] <= cnt_q[g] + 1'b1;
                if (end_ok) begin
                    done_q[g] <= 1'b1;
                    fld_q[g]  <= err_field(mac_err, ovsz_q || ovsz_hit);
                end
            end else if (sel_pop) begin
                done_q[g] <= 1'b0;
            end
        end
    end

    // Ring pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            head_q <= '0;
            tail_q <= '0;
            cur_q  <= '0;
            occ_q  <= '0;
        end else begin
            if (accept) begin
                cur_q  <= tail_q;
                tail_q <= nxt(tail_q);
            end
            if (pop) head_q <= nxt(head_q);
            occ_q <= occ_q + OCC_W'(accept) - OCC_W'(pop);
        end
    end

    // Packet-in-flight state, refusal tracking and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            recv_q <= 1'b0;
            drop_q <= 1'b0;
            ovsz_q <= 1'b0;
            cmpl_q <= 1'b0;
            ref_q  <= '0;
        end else begin
            cmpl_q <= end_ok;
            if (accept) begin
                recv_q <= 1'b1;
                ovsz_q <= 1'b0;
            end else if (end_ok) begin
                recv_q <= 1'b0;
            end else if (ovsz_hit) begin
                ovsz_q <= 1'b1;
            end
            if (refuse) begin
                drop_q <= 1'b1;
                if (ref_q != '1) ref_q <= ref_q + 1'b1;
            end else if (drop_q && mac_end) begin
                drop_q <= 1'b0;
            end
        end
    end

    assign head_cnt    = cnt_q[head_q];
    assign head_fld    = fld_q[head_q];
    assign head_done   = done_q[head_q];
    assign receiving   = recv_q;
    assign rx_complete = cmpl_q;
    assign refused_cnt = ref_q;

    // Occupancy never exceeds the descriptor capacity (R5).
    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(DEPTH));

    // A refused-packet count step only follows a full queue (R5).
    assert_refuse_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q != $past(ref_q) && !$past(clr)) |-> $past(full));

    // The completion pulse comes after the packet stopped arriving (R11).
    assert_complete_after_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> !recv_q);
endmodule

// File: rtl/rxq_read_track.sv
// Host read tracker: counts bytes consumed from the oldest packet and flags
// reads that go past what has been received. Assumes pop and clear come from
// the descriptor ring and the status block; the underrun flag is sticky.
module rxq_read_track
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             host_rd,
    input  logic             pop,
    input  logic             empty,
    input  logic [LEN_W-1:0] head_cnt,
    output logic [LEN_W-1:0] rd_cnt,
    output logic             underrun
);
    logic rd_ok;

    // A read is valid only while unread bytes of the oldest packet exist.
    assign rd_ok = !empty && (rd_cnt < head_cnt);

    // Consumed counter: restarts on pop, advances on valid reads.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_cnt <= '0;
        end else if (pop) begin
            rd_cnt <= '0;
        end else if (host_rd && rd_ok) begin
            rd_cnt <= rd_cnt + 1'b1;
        end
    end

    // Sticky underrun: any read with nothing available sets it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            underrun <= 1'b0;
        end else if (host_rd && !rd_ok) begin
            underrun <= 1'b1;
        end
    end

    // Once set, underrun holds until a clear (R8).
    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(underrun) && !$past(clr)) |-> underrun);

    // Consumed bytes never pass the bytes the ring holds for the head (R7).
    assert_rd_within_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |-> rd_cnt <= head_cnt);
endmodule

// File: rtl/rxq_status_fmt.sv
// Status formatter: packs the head descriptor into the host status word.
// Assumes the head fields are only meaningful while the ring is not empty.
module rxq_status_fmt
    import rxq_pkg::*;
(
    input  logic              empty,
    input  logic              head_done,
    input  logic [LEN_W-1:0]  head_cnt,
    input  logic [3:0]        head_fld,
    output logic [STAT_W-1:0] status_word
);
    logic busy;

    // Busy when nothing queued or the head packet is still arriving.
    always_comb begin
        busy        = empty || !head_done;
        status_word = {busy,
                       busy  ? 4'b0000 : head_fld,
                       empty ? {LEN_W{1'b0}} : head_cnt};
    end
endmodule

// File: rtl/rx_pkt_status_queue.sv
// Top: receive packet status queue. Ties the descriptor ring, the host read
// tracker and the status formatter together. Assumes all strobes are
// synchronous single-cycle pulses; rx_reset acts as a block-local clear.
module rx_pkt_status_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int MAX_LEN = 1514,
    parameter int REF_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_start,
    input  logic              mac_byte,
    input  logic              mac_end,
    input  logic [2:0]        mac_err,
    input  logic              host_rd,
    input  logic              host_discard,
    input  logic              rx_reset,
    output logic [15:0]       status_word,
    output logic [10:0]       rd_count,
    output logic              receiving,
    output logic              stat_overrun,
    output logic              rx_underrun,
    output logic              adapter_fail,
    output logic              rx_complete,
    output logic [REF_W-1:0]  refused_cnt
);
    logic [LEN_W-1:0] head_cnt;
    logic [3:0]       head_fld;
    logic             head_done, empty, full, pop, underrun;

    rxq_desc_store #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .REF_W(REF_W)) i_store (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset),
        .mac_start(mac_start), .mac_byte(mac_byte), .mac_end(mac_end),
        .mac_err(mac_err), .pop_req(host_discard),
        .head_cnt(head_cnt), .head_fld(head_fld), .head_done(head_done),
        .empty(empty), .full(full), .receiving(receiving),
        .rx_complete(rx_complete), .pop(pop), .refused_cnt(refused_cnt)
    );

    rxq_read_track i_track (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset),
        .host_rd(host_rd), .pop(pop), .empty(empty), .head_cnt(head_cnt),
        .rd_cnt(rd_count), .underrun(underrun)
    );

    rxq_status_fmt i_fmt (
        .empty(empty), .head_done(head_done), .head_cnt(head_cnt),
        .head_fld(head_fld), .status_word(status_word)
    );

    assign stat_overrun = full;
    assign rx_underrun  = underrun;
    assign adapter_fail = underrun;

    // When a completion pulses, the head must be a completed packet (R11).
    assert_complete_shows_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> !status_word[15]);
endmodule

// File: tb/test_rx_pkt_status_queue.sv
module test_rx_pkt_status_queue;
    localparam int DEPTH   = 4;
    localparam int MAX_LEN = 20;
    localparam int REF_W   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mac_start = 0, mac_byte = 0, mac_end = 0;
    logic [2:0] mac_err = 0;
    logic host_rd = 0, host_discard = 0, rx_reset = 0;
    logic [15:0] status_word;
    logic [10:0] rd_count;
    logic receiving, stat_overrun, rx_underrun, adapter_fail, rx_complete;
    logic [REF_W-1:0] refused_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rx_pkt_status_queue #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .REF_W(REF_W)) i_rx_pkt_status_queue (
        .clk(clk), .rst_n(rst_n), .mac_start(mac_start), .mac_byte(mac_byte),
        .mac_end(mac_end), .mac_err(mac_err), .host_rd(host_rd),
        .host_discard(host_discard), .rx_reset(rx_reset),
        .status_word(status_word), .rd_count(rd_count), .receiving(receiving),
        .stat_overrun(stat_overrun), .rx_underrun(rx_underrun),
        .adapter_fail(adapter_fail), .rx_complete(rx_complete),
        .refused_cnt(refused_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, entered and left at a falling edge.
    task automatic cyc(input logic s, input logic b, input logic e, input logic [2:0] er,
                       input logic r, input logic d, input logic x);
        mac_start = s; mac_byte = b; mac_end = e; mac_err = er;
        host_rd = r; host_discard = d; rx_reset = x;
        @(negedge clk);
        mac_start = 0; mac_byte = 0; mac_end = 0; mac_err = 0;
        host_rd = 0; host_discard = 0; rx_reset = 0;
    endtask

    task automatic idle();      cyc(0,0,0,0,0,0,0); endtask
    task automatic discard();   cyc(0,0,0,0,0,1,0); endtask
    task automatic rd();        cyc(0,0,0,0,1,0,0); endtask
    task automatic send_pkt(input int n, input logic [2:0] er);
        cyc(1,0,0,0,0,0,0);
        for (int i = 0; i < n; i++) cyc(0,1,0,0,0,0,0);
        cyc(0,0,1,er,0,0,0);
    endtask

    task automatic t_reset();
        chk("R1 status", status_word, 16'h8000);
        chk("R1 rd_count", rd_count, 0);
        chk("R1 flags", {receiving, stat_overrun, rx_underrun, adapter_fail, rx_complete}, 0);
        chk("R1 refused", refused_cnt, 0);
    endtask

    task automatic t_progress();
        cyc(1,0,0,0,0,0,0);
        for (int i = 0; i < 3; i++) cyc(0,1,0,0,0,0,0);
        chk("R2 receiving", receiving, 1);
        chk("R2 status", status_word, 16'h8003);
        for (int i = 0; i < 3; i++) rd();
        chk("R7 rd_count", rd_count, 3);
        chk("R7 no underrun", rx_underrun, 0);
        cyc(0,0,1,0,0,0,0);
        chk("R11 pulse", rx_complete, 1);
        chk("R3 status", status_word, 16'h0003);
        chk("R2 receiving off", receiving, 0);
        idle();
        chk("R11 one cycle", rx_complete, 0);
        discard();
        chk("R9 empty", status_word, 16'h8000);
        chk("R9 rd reset", rd_count, 0);
    endtask

    task automatic t_codes();
        logic [3:0] fl [6] = '{4'b0000, 4'b1000, 4'b1011, 4'b1100, 4'b1101, 4'b0010};
        for (int c = 0; c < 6; c++) begin
            send_pkt(5, 3'(c));
            chk("R3 code", status_word, {1'b0, fl[c], 11'd5});
            discard();
        end
    endtask

    task automatic t_oversize();
        send_pkt(25, 0);
        chk("R4 oversize", status_word, 16'h4814);
        discard();
        send_pkt(20, 0);
        chk("R4 at limit", status_word, 16'h0014);
        discard();
        send_pkt(21, 0);
        chk("R4 one over", status_word, 16'h4814);
        discard();
        send_pkt(25, 3'd4);
        chk("R4 mac wins", status_word, 16'h6814);
        discard();
    endtask

    task automatic t_full();
        for (int n = 1; n <= 4; n++) send_pkt(n, 0);
        chk("R5 full", stat_overrun, 1);
        send_pkt(7, 0);
        chk("R5 refused", refused_cnt, 1);
        chk("R5 no complete", rx_complete, 0);
        chk("R13 head first", status_word, 16'h0001);
        discard();
        chk("R6 cleared", stat_overrun, 0);
        chk("R13 second", status_word, 16'h0002);
        send_pkt(6, 0);
        chk("R5 accepted", rx_complete, 1);
        discard();
        chk("R13 third", status_word, 16'h0003);
        discard();
        chk("R13 fourth", status_word, 16'h0004);
        discard();
        chk("R13 fifth", status_word, 16'h0006);
        discard();
        chk("R13 drained", status_word, 16'h8000);
        discard();
        chk("R10 empty discard", status_word, 16'h8000);
        chk("R10 refused kept", refused_cnt, 1);
    endtask

    task automatic t_discard_busy();
        cyc(1,0,0,0,0,0,0);
        cyc(0,1,0,0,0,0,0);
        cyc(0,1,0,0,0,0,0);
        discard();
        chk("R10 busy discard", status_word, 16'h8002);
        chk("R10 still receiving", receiving, 1);
        cyc(0,0,1,0,0,0,0);
        chk("R10 kept packet", status_word, 16'h0002);
        discard();
    endtask

    task automatic t_underrun();
        send_pkt(2, 0);
        rd(); rd();
        chk("R7 read all", rd_count, 2);
        chk("R8 not yet", rx_underrun, 0);
        rd();
        chk("R8 underrun", rx_underrun, 1);
        chk("R8 fail", adapter_fail, 1);
        chk("R8 rd held", rd_count, 2);
        discard();
        idle();
        chk("R8 sticky", rx_underrun, 1);
        cyc(0,0,0,0,0,0,1);
        chk("R12 underrun clr", {rx_underrun, adapter_fail}, 0);
        chk("R12 refused clr", refused_cnt, 0);
        rd();
        chk("R8 empty read", rx_underrun, 1);
        cyc(0,0,0,0,0,0,1);
    endtask

    task automatic t_rxreset();
        send_pkt(3, 0);
        cyc(1,0,0,0,0,0,0);
        cyc(0,1,0,0,0,0,0);
        cyc(0,0,0,0,0,0,1);
        chk("R12 empty", status_word, 16'h8000);
        chk("R12 not receiving", receiving, 0);
        cyc(0,0,1,0,0,0,0);
        chk("R12 stale end", rx_complete, 0);
        chk("R12 still empty", status_word, 16'h8000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_progress();
        t_codes();
        t_oversize();
        t_full();
        t_discard_busy();
        t_underrun();
        t_rxreset();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule